// File: doc/BRIEF.md
# Late Collision Guard

This block sits beside a half-duplex Ethernet transmitter and decides what happens when the medium reports a collision. It follows the transmit byte stream, which is a valid strobe with start-of-frame and end-of-frame markers, and keeps a count of the bytes already sent in the current frame. It samples the collision input on every clock edge. A collision that arrives once 64 or more bytes of the frame are out is a late collision. The block then raises a one-cycle discard pulse, ignores the rest of that frame and sets a sticky status flag. A collision that arrives earlier raises a one-cycle early-collision pulse. A separate retry unit acts on that pulse.

The controller has four states. `ST_IDLE` means no frame is open. `ST_SEND` means a frame is being sent and no collision has been seen yet. `ST_EARLY_HOLD` follows an early collision and `ST_LATE_DROP` follows a late one. Both of these wait for the end of the frame. The transitions are:

- *open*: any state goes to `ST_SEND`, or to `ST_EARLY_HOLD` if a collision arrives with the first byte, when a start-of-frame byte is seen.
- *early*: `ST_SEND` goes to `ST_EARLY_HOLD`.
- *late*: `ST_SEND` goes to `ST_LATE_DROP`.
- *close*: any open state goes to `ST_IDLE` on the end-of-frame byte.

The status flag is cleared by the hardware reset. It is also cleared by a software reset request, but that request waits until no frame is open.

Top module: `late_coll_guard`

## Requirements
- R1: While `rst_n` is low, `discard_o`, `early_coll_o` and `late_sts_o` are all 0, and any late status bit set earlier is cleared.
- R2: A frame is open from the cycle that carries `tx_valid`=1 with `tx_sof`=1, up to and including the cycle that carries `tx_valid`=1 with `tx_eof`=1. A frame that has no collision produces no pulse on either output.
- R3: A collision sampled while a frame is open, in a cycle before which at least 64 bytes (cycles with `tx_valid`=1) of that frame were completed, produces `discard_o`=1 for exactly one cycle, the cycle after the collision was sampled.
- R4: `late_sts_o` becomes 1 in the same cycle as the discard pulse. It stays 1 across later frames until a reset clears it.
- R5: A collision sampled while a frame is open with fewer than 64 bytes completed before that cycle, including the start-of-frame cycle itself, produces `early_coll_o`=1 for exactly one cycle, the cycle after it was sampled. It produces no discard pulse and leaves `late_sts_o` unchanged.
- R6: After the first collision of a frame, any further collision up to the end of that frame produces no pulse.
- R7: A collision while no frame is open produces no pulse and leaves `late_sts_o` unchanged. This holds even when bytes without a start-of-frame marker are on the bus.
- R8: A one-cycle `soft_rst` pulse clears `late_sts_o`. If no frame is open, the flag is 0 one cycle later. If a frame is open, the flag stays 1 until that frame has ended and is 0 within two cycles after the end-of-frame cycle.
- R9: The byte count saturates rather than wrapping. A collision after 290 completed bytes is still late.
- R10: A collision sampled in the end-of-frame cycle is judged like any other cycle of the frame.
- R11: A start-of-frame byte seen while a frame is already open begins a new frame, and the byte count restarts from that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| soft_rst | input | 1 | Software reset request pulse; clears the status flag once no frame is open |
| tx_valid | input | 1 | A transmit byte is sent this cycle |
| tx_sof | input | 1 | This byte is the first of a frame |
| tx_eof | input | 1 | This byte is the last of a frame |
| coll_in | input | 1 | Collision reported by the medium |
| discard_o | output | 1 | One-cycle pulse: the current frame is dropped after a late collision |
| early_coll_o | output | 1 | One-cycle pulse: collision within the first 64 bytes, handed to the retry unit |
| late_sts_o | output | 1 | Sticky late-collision status flag, read-only |

## Verification
The bench targets the threshold itself. A collision after exactly 63 completed bytes must be early and one after exactly 64 must be late, so an off-by-one comparison shows up as the wrong pulse. Collisions at 290 bytes expose a counter that wraps, because a wrapped count reports early instead of late. Collisions in the end-of-frame cycle, a second collision in the same frame, collisions on an idle line and a restart in the middle of a frame expose, in order: a frame boundary that closes too soon, duplicate pulses, spurious pulses, and a count that keeps running across frames. A software reset issued in the middle of a frame catches a design that clears the flag at once instead of waiting for the frame to end.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    // Controller states of the late-collision guard.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SEND       = 2'd1,
        ST_EARLY_HOLD = 2'd2,
        ST_LATE_DROP  = 2'd3
    } lcg_state_e;

    // Default byte threshold for a late collision.
    localparam int unsigned LCG_LATE_BYTES = 64;

endpackage

// File: rtl/lcg_byte_counter.sv
module lcg_byte_counter #(
    parameter int unsigned LATE_THR = lcg_pkg::LCG_LATE_BYTES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic step_i,
    output logic reached_o
);

    localparam int unsigned CNT_W = $clog2(LATE_THR + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LATE_THR);

    logic [CNT_W-1:0] cnt_q;

    // Count of bytes completed in the frame; stops at the threshold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(1);
        end else if (step_i && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign reached_o = (cnt_q == LIMIT);

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R11
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !reached_o || (LATE_THR <= 1));

endmodule

// File: rtl/lcg_tx_fsm.sv
module lcg_tx_fsm
    import lcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic tx_sof,
    input  logic tx_eof,
    input  logic coll_in,
    input  logic reached_i,
    output logic start_o,
    output logic step_o,
    output logic late_hit_o,
    output logic idle_o,
    output logic discard_o,
    output logic early_o
);

    lcg_state_e state_q, state_d;
    logic sof_hit, eof_hit;
    logic late_hit, early_hit;
    logic discard_q, early_q;

    assign sof_hit = tx_valid && tx_sof;
    assign eof_hit = tx_valid && tx_eof;

    // Next-state and collision classification.
    always_comb begin
        state_d   = state_q;
        late_hit  = 1'b0;
        early_hit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_hit) begin
                    early_hit = coll_in;
                    state_d   = eof_hit ? ST_IDLE : (coll_in ? ST_EARLY_HOLD : ST_SEND);
                end
            end
            ST_SEND: begin
                if (sof_hit) begin
                    early_hit = coll_in;
                    state_d   = eof_hit ? ST_IDLE : (coll_in ? ST_EARLY_HOLD : ST_SEND);
                end else if (coll_in) begin
                    if (reached_i) begin
                        late_hit = 1'b1;
                        state_d  = eof_hit ? ST_IDLE : ST_LATE_DROP;
                    end else begin
                        early_hit = 1'b1;
                        state_d   = eof_hit ? ST_IDLE : ST_EARLY_HOLD;
                    end
                end else if (eof_hit) begin
                    state_d = ST_IDLE;
                end
            end
            ST_EARLY_HOLD, ST_LATE_DROP: begin
                if (sof_hit) begin
                    early_hit = coll_in;
                    state_d   = eof_hit ? ST_IDLE : (coll_in ? ST_EARLY_HOLD : ST_SEND);
                end else if (eof_hit) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pulse outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            discard_q <= 1'b0;
            early_q   <= 1'b0;
        end else begin
            discard_q <= late_hit;
            early_q   <= early_hit;
        end
    end

    assign start_o    = sof_hit;
    assign step_o     = tx_valid && !tx_sof && (state_q != ST_IDLE);
    assign late_hit_o = late_hit;
    assign idle_o     = (state_q == ST_IDLE);
    assign discard_o  = discard_q;
    assign early_o    = early_q;

    // R3
    discard_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard_q |=> !discard_q);

    // R5
    early_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_q |=> !early_q);

    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(discard_q && early_q));

    // R7
    idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sof_hit) |=> (!discard_q && !early_q));

    // R6
    one_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EARLY_HOLD || state_q == ST_LATE_DROP) && !sof_hit)
        |=> (!discard_q && !early_q));

endmodule

// File: rtl/lcg_status.sv
module lcg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic idle_i,
    input  logic late_i,
    output logic sts_o
);

    logic sts_q, pend_q;
    logic apply;

    // A software reset request takes effect only once no frame is open.
    assign apply = (soft_rst_i || pend_q) && idle_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q || soft_rst_i) && !apply;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (late_i) begin
            sts_q <= 1'b1;
        end else if (apply) begin
            sts_q <= 1'b0;
        end
    end

    assign sts_o = sts_q;

    // R4
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_i |=> sts_q);

    // R8
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !idle_i) |=> sts_q);

endmodule

// File: rtl/late_coll_guard.sv
module late_coll_guard #(
    parameter int unsigned LATE_THR = lcg_pkg::LCG_LATE_BYTES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic tx_valid,
    input  logic tx_sof,
    input  logic tx_eof,
    input  logic coll_in,
    output logic discard_o,
    output logic early_coll_o,
    output logic late_sts_o
);

    logic start, step, reached, late_hit, idle;

    lcg_byte_counter #(.LATE_THR(LATE_THR)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .step_i    (step),
        .reached_o (reached)
    );

    lcg_tx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_valid),
        .tx_sof     (tx_sof),
        .tx_eof     (tx_eof),
        .coll_in    (coll_in),
        .reached_i  (reached),
        .start_o    (start),
        .step_o     (step),
        .late_hit_o (late_hit),
        .idle_o     (idle),
        .discard_o  (discard_o),
        .early_o    (early_coll_o)
    );

    lcg_status u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .idle_i     (idle),
        .late_i     (late_hit),
        .sts_o      (late_sts_o)
    );

    // R4
    discard_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discard_o |-> late_sts_o);

endmodule

// File: tb/test_late_coll_guard.sv
module test_late_coll_guard;

    localparam int CLK_P = 10;
    localparam int NV = 8;
    // Columns: frame length, index of the byte cycle carrying the collision (-1 none),
    // expected result (0 none, 1 early, 2 late).
    localparam int VEC [NV][3] = '{
        '{10,  -1,  0},
        '{70,   0,  1},
        '{70,  63,  1},
        '{70,  64,  2},
        '{70,  69,  2},   // R10 collision in end-of-frame cycle
        '{64,  63,  1},   // R10 early in end-of-frame cycle
        '{100, 65,  2},
        '{300, 290, 2}    // R9 saturation, no wrap
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic tx_valid = 1'b0, tx_sof = 1'b0, tx_eof = 1'b0, coll_in = 1'b0;
    logic discard_o, early_coll_o, late_sts_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    late_coll_guard i_late_coll_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .tx_valid     (tx_valid),
        .tx_sof       (tx_sof),
        .tx_eof       (tx_eof),
        .coll_in      (coll_in),
        .discard_o    (discard_o),
        .early_coll_o (early_coll_o),
        .late_sts_o   (late_sts_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic e, input logic c);
        tx_valid = v; tx_sof = s; tx_eof = e; coll_in = c;
        @(negedge clk);
    endtask

    // One frame of len back-to-back bytes; collisions at byte cycles c1 and c2.
    task automatic run_frame(input int len, input int c1, input int c2,
                             output int nd, output int ne, output int di, output int ei);
        nd = 0; ne = 0; di = -1; ei = -1;
        for (int i = 0; i < len; i++) begin
            drive(1'b1, i == 0, i == len - 1, (i == c1) || (i == c2));
            if (discard_o) begin nd++; if (di < 0) di = i; end
            if (early_coll_o) begin ne++; if (ei < 0) ei = i; end
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        if (discard_o) nd++;
        if (early_coll_o) ne++;
    endtask

    initial begin
        int nd, ne, di, ei;
        bit exp_sts;
        exp_sts = 1'b0;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 discard in reset", discard_o, 0);
        check("R1 early in reset", early_coll_o, 0);
        check("R1 status in reset", late_sts_o, 0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0);

        // Table walk: R2, R3, R4, R5, R9, R10
        for (int k = 0; k < NV; k++) begin
            string rq;
            rq = (VEC[k][2] == 2) ? "R3" : (VEC[k][2] == 1) ? "R5" : "R2";
            run_frame(VEC[k][0], VEC[k][1], -1, nd, ne, di, ei);
            check($sformatf("%s row %0d discard count", rq, k), nd, VEC[k][2] == 2 ? 1 : 0);
            check($sformatf("%s row %0d early count", rq, k), ne, VEC[k][2] == 1 ? 1 : 0);
            if (VEC[k][2] == 2) check($sformatf("R3 row %0d discard cycle", k), di, VEC[k][1]);
            if (VEC[k][2] == 1) check($sformatf("R5 row %0d early cycle", k), ei, VEC[k][1]);
            if (VEC[k][2] == 2) exp_sts = 1'b1;
            check($sformatf("R4 row %0d status", k), late_sts_o, int'(exp_sts));
        end

        // R7 collisions with no frame open, including bytes without start marker
        for (int i = 0; i < 6; i++) begin
            drive(i[0], 1'b0, 1'b0, 1'b1);
            check("R7 idle collision discard", discard_o, 0);
            check("R7 idle collision early", early_coll_o, 0);
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R7 status unchanged", late_sts_o, 1);

        // R6 second collision in the same frame
        run_frame(80, 66, 70, nd, ne, di, ei);
        check("R6 two late collisions, one discard", nd, 1);
        check("R6 two late collisions, no early", ne, 0);
        run_frame(80, 5, 70, nd, ne, di, ei);
        check("R6 early then late, one early", ne, 1);
        check("R6 early then late, no discard", nd, 0);

        // R8 software reset during a frame is deferred
        for (int i = 0; i < 20; i++) begin
            soft_rst = (i == 5);
            drive(1'b1, i == 0, i == 19, 1'b0);
            if (i == 10) check("R8 status held while frame open", late_sts_o, 1);
        end
        soft_rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 status cleared after frame end", late_sts_o, 0);

        // R8 software reset while idle
        run_frame(70, 66, -1, nd, ne, di, ei);
        check("R4 status set again", late_sts_o, 1);
        soft_rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        soft_rst = 1'b0;
        check("R8 idle soft reset clears status", late_sts_o, 0);

        // R11 restart in the middle of a frame: 40 bytes, then new start
        nd = 0; ne = 0; ei = -1;
        for (int i = 0; i < 80; i++) begin
            drive(1'b1, (i == 0) || (i == 40), i == 79, i == 70);
            if (discard_o) nd++;
            if (early_coll_o) begin ne++; ei = i; end
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 restart count gives early", ne, 1);
        check("R11 restart early cycle", ei, 70);
        check("R11 restart no discard", nd, 0);
        nd = 0;
        for (int i = 0; i < 120; i++) begin
            drive(1'b1, (i == 0) || (i == 40), i == 119, i == 104);
            if (discard_o) nd++;
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R11 restart then 64 bytes is late", nd, 1);

        // R1 hardware reset clears a set status
        check("R1 status set before reset", late_sts_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 hardware reset clears status", late_sts_o, 0);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 status stays clear", late_sts_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule